// File: doc/BRIEF.md
# Muted-Capable Asynchronous Serial Receiver

This block takes an asynchronous serial line in 8N1 form (a low start bit, DW data bits sent least significant first, one high stop bit) and turns each frame into a word held in a receive data register. The line timing comes from an external enable, `tick16`, that pulses once per sixteenth of a bit. Each bit is judged by a majority vote of three samples taken around the middle of the bit. The block keeps five flags: data-ready, line-quiet, overrun, noise and framing error. It raises one interrupt request from those flags, under two enable inputs.

Software can put the receiver in a muted state. In that state no receive flag may become set, and received words are dropped. Software selects how the receiver leaves the muted state. In one mode it wakes after a whole frame time of quiet line. In the other it wakes on a word whose top bit is 1, and that word is delivered as ordinary data, so it can act as an address. Flags are cleared by a status-read strobe followed by a data-read strobe. Dropping the receive enable stops reception and clears every flag.

Top module: `uart_rx_mute`

## Requirements
- R1: The receiver hunts for a start bit only while `rx_en` is 1. A frame sent while `rx_en` is 0 leaves `full` at 0.
- R2: In the cycle after a clock edge that sees `rx_en` at 0, `full`, `idle`, `overrun`, `noise` and `framing` are all 0.
- R3: While `muted` is 1, none of the five receive flags can go from 0 to 1, and words that do not wake the receiver are dropped.
- R4: A `mute_clr` pulse leaves `muted` at 0 on the next cycle. Recognising the selected wake-up condition also clears `muted` by itself.
- R5: With `wake_sel`=0 (quiet-line wake), a `mute_set` pulse is refused while the line has been quiet for a frame time. Once the line has stayed high for (DW+2)*16 ticks, `muted` clears and `idle` stays 0.
- R6: With `wake_sel`=1 (address wake), a word whose bit DW-1 is 1 clears `muted`, sets `full` and appears on `rx_data`. A word whose top bit is 0 is dropped and the receiver stays muted.
- R7: A valid frame loads its data bits, least significant first, into `rx_data` and sets `full`.
- R8: If a frame completes while `full` is 1, `overrun` sets, the new word is dropped, and `rx_data` keeps the word it held.
- R9: If any one of the three mid-bit samples of a frame disagrees with the others, `noise` sets along with the loaded word. A stop bit sampled low sets `framing`.
- R10: After a frame has been received, `idle` sets once the line has stayed high for (DW+2)*16 ticks.
- R11: A `stat_rd` pulse followed by a `data_rd` pulse clears `full`, `overrun`, `noise`, `framing` and `idle`. A `data_rd` pulse with no `stat_rd` before it has no effect.
- R12: `irq` is 1 when `rx_ie` is 1 and `full` or `overrun` is 1, or when `idle_ie` is 1 and `idle` is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial input line, asynchronous to `clk` |
| rx_en | input | 1 | Receiver enable |
| wake_sel | input | 1 | Wake mode: 0 = quiet line, 1 = top-bit address word |
| mute_set | input | 1 | Pulse that requests the muted state |
| mute_clr | input | 1 | Pulse that leaves the muted state |
| stat_rd | input | 1 | Status-read strobe; arms the flag clear |
| data_rd | input | 1 | Data-read strobe; clears the flags if armed |
| rx_ie | input | 1 | Enables the interrupt for data-ready or overrun |
| idle_ie | input | 1 | Enables the interrupt for a quiet line |
| rx_data | output | DW | Receive data register |
| full | output | 1 | A word is waiting to be read |
| idle | output | 1 | Quiet line seen after activity |
| overrun | output | 1 | A word was dropped because `full` was still set |
| noise | output | 1 | Sample disagreement in the loaded word |
| framing | output | 1 | The loaded word had a low stop bit |
| muted | output | 1 | The receiver is muted |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the rules that need no frame context. These are: the clear after disable, no flag rising while muted, the immediate exit on `mute_clr`, the register holding its word across an overrun, `rx_data` changing only when a word is delivered, and the interrupt conditions. Only the bench scenarios can show how a frame is decoded. That covers bit order, majority voting under a single-sample glitch, a low stop bit, and the two wake modes: a non-address word dropped and then an address word delivered, and a frame dropped under mute followed by a wake after a quiet frame time. The same holds for the refused mute request on a quiet line and the two-step clear sequence.

// File: rtl/uart_rx_mute.sv
module uart_rx_mute #(
  parameter int DW  = 8,
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic          wake_sel,
  input  logic          mute_set,
  input  logic          mute_clr,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          rx_ie,
  input  logic          idle_ie,
  output logic [DW-1:0] rx_data,
  output logic          full,
  output logic          idle,
  output logic          overrun,
  output logic          noise,
  output logic          framing,
  output logic          muted,
  output logic          irq
);
  localparam int CW    = $clog2(OSR);
  localparam int BW    = (DW > 1) ? $clog2(DW) : 1;
  localparam int FRAME = (DW + 2) * OSR;
  localparam int IW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] SMP_A = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] SMP_B = CW'(OSR/2);
  localparam logic [CW-1:0] SMP_C = CW'(OSR/2 + 1);
  localparam logic [BW-1:0] LAST  = BW'(DW - 1);
  localparam logic [IW-1:0] QMAX  = IW'(FRAME);
  localparam logic [IW-1:0] QPRE  = IW'(FRAME - 1);

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  st_t           st;
  logic          rx_meta, rxs;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic          s0, s1, noisy, active, armed;
  logic [IW-1:0] qcnt;

  wire maj      = (s0 & s1) | (s0 & rxs) | (s1 & rxs);
  wire disagree = (s0 != s1) | (s1 != rxs);
  wire quiet    = (qcnt == QMAX);
  wire at_end   = tick16 && st == STOP && cnt == SMP_C;
  wire wake_adr = muted && wake_sel && shreg[DW-1];

  assign irq = (rx_ie & (full | overrun)) | (idle_ie & idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_meta <= 1'b1;
      rxs     <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rxs     <= rx_meta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; cnt <= '0; bitn <= '0; shreg <= '0;
      s0 <= 1'b1; s1 <= 1'b1; noisy <= 1'b0; active <= 1'b0;
      armed <= 1'b0; qcnt <= '0; rx_data <= '0;
      full <= 1'b0; idle <= 1'b0; overrun <= 1'b0;
      noise <= 1'b0; framing <= 1'b0; muted <= 1'b0;
    end else begin
      if (mute_clr) muted <= 1'b0;
      else if (mute_set && !(!wake_sel && quiet)) muted <= 1'b1;

      if (stat_rd) armed <= 1'b1;
      if (data_rd && armed) begin
        full <= 1'b0; overrun <= 1'b0; noise <= 1'b0;
        framing <= 1'b0; idle <= 1'b0; armed <= 1'b0;
      end

      if (!rx_en) begin
        st <= HUNT; cnt <= '0; qcnt <= '0; active <= 1'b0;
        full <= 1'b0; idle <= 1'b0; overrun <= 1'b0;
        noise <= 1'b0; framing <= 1'b0;
      end else if (tick16) begin
        if (st != HUNT || !rxs) qcnt <= '0;
        else if (!quiet) qcnt <= qcnt + 1'b1;

        if (st == HUNT && rxs && qcnt == QPRE) begin
          if (muted && !wake_sel && !mute_clr) muted <= 1'b0;
          else if (!muted && active) idle <= 1'b1;
          active <= 1'b0;
        end

        if (st == HUNT) begin
          if (!rxs) begin
            st <= START; cnt <= '0; noisy <= 1'b0;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == SMP_A) s0 <= rxs;
          if (cnt == SMP_B) s1 <= rxs;
          if (cnt == SMP_C) begin
            if (disagree) noisy <= 1'b1;
            unique case (st)
              START: if (maj) st <= HUNT;
                     else begin st <= DATA; bitn <= '0; active <= 1'b1; end
              DATA: begin
                shreg <= {maj, shreg[DW-1:1]};
                bitn  <= bitn + 1'b1;
                if (bitn == LAST) st <= STOP;
              end
              default: st <= HUNT;
            endcase
          end
        end

        if (at_end && (!muted || wake_adr)) begin
          if (wake_adr) muted <= 1'b0;
          if (full) overrun <= 1'b1;
          else begin
            rx_data <= shreg;
            full    <= 1'b1;
            noise   <= noisy | disagree;
            framing <= !maj;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_mute_chk.sv
module uart_rx_mute_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          mute_clr,
  input logic          rx_ie,
  input logic          idle_ie,
  input logic [DW-1:0] rx_data,
  input logic          full,
  input logic          idle,
  input logic          overrun,
  input logic          noise,
  input logic          framing,
  input logic          muted,
  input logic          irq
);
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !(full | idle | overrun | noise | framing));

  a_r3_mute_blocks_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full) || $rose(idle) || $rose(overrun) || $rose(noise) || $rose(framing))
      |-> !($past(muted) && muted));

  a_r4_clear_exits_mute: assert property (@(posedge clk) disable iff (!rst_n)
    mute_clr |=> !muted);

  a_r8_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (full && $stable(rx_data)));

  a_r7_data_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> $rose(full));

  a_r12_irq_rx_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && (full || overrun)) |-> irq);

  a_r12_irq_idle_source: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rx_ie && (full || overrun))) |-> (idle_ie && idle));
endmodule

bind uart_rx_mute uart_rx_mute_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_uart_rx_mute.sv
module tb_uart_rx_mute;
  localparam int BITC = 32;

  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1, rx_en = 0, wake_sel = 0;
  logic mute_set = 0, mute_clr = 0, stat_rd = 0, data_rd = 0, rx_ie = 0, idle_ie = 0;
  logic [7:0] rx_data;
  logic full, idle, overrun, noise, framing, muted, irq;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [9:0] expq[$];

  uart_rx_mute dut (.*);

  always #5 clk = ~clk;
  always @(negedge clk) tick16 <= ~tick16;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  // monitor: compare each delivered word with the scoreboard
  always @(posedge full) begin
    #1;
    if (expq.size() == 0) chk("R7 unexpected word", {22'd0, noise, framing, rx_data}, 32'h3FF);
    else begin
      logic [9:0] e;
      e = expq.pop_front();
      chk("R7/R9 word+noise+framing", {22'd0, noise, framing, rx_data}, {22'd0, e});
    end
  end

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic rd_clear();
    pulse(stat_rd);
    pulse(data_rd);
    wclk(1);
  endtask

  // glitch: bit index (0 = start, 1..8 data) with one mid sample inverted; -1 none
  task automatic send(logic [7:0] d, logic stopv, int glitch, bit expect_word);
    logic [9:0] fr;
    fr = {stopv, d, 1'b0};
    if (expect_word) expq.push_back({(glitch >= 0), !stopv, d});
    for (int b = 0; b < 10; b++) begin
      for (int c = 0; c < BITC; c++) begin
        @(negedge clk);
        if (b == glitch && (c == 18 || c == 19)) rxd = ~fr[b];
        else if (b == 9 && !stopv && c >= 24) rxd = 1'b1;
        else rxd = fr[b];
      end
    end
    @(negedge clk) rxd = 1'b1;
    wclk(4);
  endtask

  initial begin
    wclk(3);
    chk("R7 reset full", full, 0);
    chk("R10 reset idle", idle, 0);
    chk("R4 reset muted", muted, 0);
    chk("R12 reset irq", irq, 0);
    rst_n = 1;
    wclk(2);

    // R1: disabled receiver ignores a frame
    send(8'h77, 1, -1, 0);
    chk("R1 no reception while disabled", full, 0);
    rx_en = 1;
    wclk(4);

    // R7: plain word, R11 clear sequence
    send(8'h5A, 1, -1, 1);
    chk("R7 full set", full, 1);
    rd_clear();
    chk("R11 full cleared", full, 0);

    // R11: data read alone does nothing
    send(8'h3C, 1, -1, 1);
    pulse(data_rd); wclk(1);
    chk("R11 data read alone keeps full", full, 1);
    rd_clear();

    // R9: noise and framing
    send(8'hA5, 1, 3, 1);
    chk("R9 noise flag", noise, 1);
    rd_clear();
    chk("R11 noise cleared", noise, 0);
    send(8'h81, 0, -1, 1);
    chk("R9 framing flag", framing, 1);
    wclk(40);
    rd_clear();

    // R8: overrun
    rx_ie = 1;
    send(8'h11, 1, -1, 1);
    send(8'h22, 1, -1, 0);
    chk("R8 overrun set", overrun, 1);
    chk("R8 held data kept", rx_data, 8'h11);
    chk("R12 irq on overrun", irq, 1);
    rd_clear();
    chk("R12 irq low after clear", irq, 0);

    // R10: quiet line after activity
    wclk(400);
    chk("R10 idle set", idle, 1);
    chk("R12 idle masked", irq, 0);
    idle_ie = 1; wclk(1);
    chk("R12 irq on idle", irq, 1);
    rd_clear();
    idle_ie = 0;

    // R6: address wake
    wake_sel = 1;
    pulse(mute_set); wclk(1);
    chk("R6 mute accepted", muted, 1);
    send(8'h05, 1, -1, 0);
    chk("R3 dropped word no full", full, 0);
    chk("R6 still muted", muted, 1);
    send(8'h85, 1, -1, 1);
    chk("R6 woke", muted, 0);
    chk("R6 address word delivered", rx_data, 8'h85);
    rd_clear();

    // R4: explicit exit
    pulse(mute_set);
    pulse(mute_clr); wclk(1);
    chk("R4 mute_clr exits", muted, 0);

    // R5: quiet-line wake
    wake_sel = 0;
    wclk(400);
    rd_clear();
    pulse(mute_set); wclk(1);
    chk("R5 mute refused on quiet line", muted, 0);
    fork
      send(8'h44, 1, -1, 0);
      begin wclk(100); pulse(mute_set); end
    join
    chk("R5 mute accepted mid-frame", muted, 1);
    chk("R3 muted frame no full", full, 0);
    wclk(400);
    chk("R5 quiet wake", muted, 0);
    chk("R5 no idle flag on wake", idle, 0);

    // R2: disable clears
    send(8'h66, 1, -1, 1);
    chk("R7 full before disable", full, 1);
    @(negedge clk) rx_en = 0;
    wclk(2);
    chk("R2 flags cleared", {full, idle, overrun, noise, framing}, 0);
    send(8'h99, 1, -1, 0);
    chk("R1 disabled again ignores", full, 0);
    rx_en = 1;
    wclk(10);
    chk("R7 scoreboard drained", expq.size(), 0);
    finish_run();
  end
endmodule